// File: doc/BRIEF.md
# Planar Graphics Engine Register Interface

This block is the control register bank of a planar bitmap raster engine. A host reaches it through a sixteen-byte I/O window of eight 16-bit registers. Word writes are decoded into the fields the raster datapath and the bit shifter consume. Those fields cover:

- which planes may be written;
- where the drawing colour comes from, and the lead plane;
- the compare, write-source, shifter-input and register-load modes;
- the 8-bit raster operation;
- the foreground and background colours, each expanded into one 16-bit all-ones or all-zeros mask per plane;
- the 16-bit pixel mask;
- the shifter's direction, bit addresses and length.

The window exists only while the engine-enable input is high. When it is low, writes do nothing and reads see all ones, which is also what every read returns when the engine is on. The register contents are never readable.

Each register keeps a raw 16-bit shadow of what was last written. A word write to either shifter setup register produces a one-cycle re-initialise pulse for the shifter.

Byte-sized accesses are treated specially. Every byte write merges into one half of the shadow. Only a byte write to the foreground colour register takes effect on a control field. Every other byte access raises a one-cycle illegal-access flag.

Top module: `plane_ctl_regs`

## Requirements
- R1: While `eng_en` is low, writes change no register or shadow, no re-initialise pulse and no illegal-access flag is produced, and reads return 16'hFFFF.
- R2: `rdata` is 16'hFFFF for every access, at every offset and every size.
- R3: A word write to offset 0 loads `plane_we` from `wdata[7:0]`.
- R4: A word write to offset 2 loads the following fields:
  - `col_src` from bits 14:13 (00 = pattern register, 01 = background, 10 = foreground);
  - `lead_plane` from bits 11:8.
- R5: A word write to offset 4 loads the following fields:
  - `cmp_lead` as the inverse of bit 13;
  - `wr_src` from bits 12:11;
  - `shin_cpu` from bit 10;
  - `load_mode` from bits 9:8;
  - `rop` from bits 7:0.
- R6: A word write to offset 6 loads `fg_color` from the low 8 bits, and a word write to offset 0xA loads `bg_color` the same way. For each plane p from 0 to 3, bits [16p+15:16p] of the matching mask output are 16'hFFFF when colour bit p is 1 and 16'h0000 when it is 0.
- R7: A word write to offset 8 loads `pix_mask` only if `col_src` is 00 at the time of the write. Otherwise `pix_mask` keeps its value.
- R8: A word write to offset 0xC loads these fields:
  - `shift_desc` from bit 12 (1 = descending);
  - `dst_bit` from bits 7:4;
  - `src_bit` from bits 3:0.

  A word write to offset 0xE loads `shift_len` from bits 11:0. A word write to either register makes `shift_reinit` high for exactly the one cycle after the write edge.
- R9: A word write stores all 16 data bits in shadow entry addr[3:1], which appears at `shadow[16i+15:16i]`.
- R10: An access is byte-sized when `wsize` is 0 or when `addr[0]` is 1. A byte write stores `wdata[7:0]` into the high byte of shadow entry addr[3:1] if `addr[0]` is 1, and into the low byte otherwise. The other byte is left unchanged.
- R11: A byte write to offset 6 loads `fg_color` and its masks as in R6, with no flag. Every other byte access, read or write, leaves all control fields unchanged and raises `bad_access` for one cycle after the edge.
- R12: After reset these values hold:
  - `rop` = 8'hF0;
  - `shift_len` = 12'h00F;
  - every other field, mask and shadow entry is 0;
  - `shift_reinit` and `bad_access` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_en | input | 1 | Engine enable; window present when high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Byte offset within the window |
| wsize | input | 1 | 1 = word access, 0 = byte access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, always all ones |
| plane_we | output | 8 | Plane write enables |
| col_src | output | 2 | Colour source select |
| lead_plane | output | 4 | Lead plane number |
| cmp_lead | output | 1 | Compare lead plane |
| wr_src | output | 2 | Write data source |
| shin_cpu | output | 1 | Shifter input is CPU data |
| load_mode | output | 2 | Pattern register load mode |
| rop | output | 8 | Raster operation |
| fg_color | output | 8 | Foreground colour |
| bg_color | output | 8 | Background colour |
| fg_mask | output | 64 | Per-plane foreground masks, plane p at [16p+15:16p] |
| bg_mask | output | 64 | Per-plane background masks |
| pix_mask | output | 16 | Pixel mask |
| shift_desc | output | 1 | Shift direction, 1 = descending |
| dst_bit | output | 4 | Shifter destination bit address |
| src_bit | output | 4 | Shifter source bit address |
| shift_len | output | 12 | Shifter bit length |
| shift_reinit | output | 1 | One-cycle shifter re-initialise pulse |
| bad_access | output | 1 | One-cycle illegal byte access flag |
| shadow | output | 128 | Raw shadows, entry i at [16i+15:16i] |

## Verification
The hardest case is the gated pixel mask. Whether a write to offset 8 takes effect depends on state left behind by an earlier write to offset 2. The stimulus therefore first sets a non-zero colour source and writes the mask, expecting no change. It then clears the source and repeats the write with a new value. A second difficulty is a word-sized strobe at an odd address, which must be demoted to a byte merge into the upper shadow half. The bench drives this with `wsize` high and `addr[0]` set, and then checks the shadow, the foreground colour and the flag together.

// File: rtl/plane_ctl_regs.sv
module plane_ctl_regs #(
  parameter int DW    = 16,
  parameter int NREG  = 8,
  parameter int NCOL  = 4,
  parameter int LENW  = 12,
  parameter logic [7:0]      ROP_RST = 8'hF0,
  parameter logic [LENW-1:0] LEN_RST = 12'h00F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               eng_en,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [3:0]         addr,
  input  logic               wsize,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  output logic [7:0]         plane_we,
  output logic [1:0]         col_src,
  output logic [3:0]         lead_plane,
  output logic               cmp_lead,
  output logic [1:0]         wr_src,
  output logic               shin_cpu,
  output logic [1:0]         load_mode,
  output logic [7:0]         rop,
  output logic [7:0]         fg_color,
  output logic [7:0]         bg_color,
  output logic [NCOL*DW-1:0] fg_mask,
  output logic [NCOL*DW-1:0] bg_mask,
  output logic [DW-1:0]      pix_mask,
  output logic               shift_desc,
  output logic [3:0]         dst_bit,
  output logic [3:0]         src_bit,
  output logic [LENW-1:0]    shift_len,
  output logic               shift_reinit,
  output logic               bad_access,
  output logic [NREG*DW-1:0] shadow
);
  localparam int IW = $clog2(NREG);

  logic [DW-1:0] raw [NREG];
  logic          narrow, wword, wbyte, fg_byte, any_acc;
  logic [IW-1:0] idx;

  assign idx     = addr[IW:1];
  assign narrow  = ~wsize | addr[0];
  assign wword   = eng_en & wr_en & ~narrow;
  assign wbyte   = eng_en & wr_en & narrow;
  assign fg_byte = wbyte & (addr == 4'h6);
  assign any_acc = eng_en & (wr_en | rd_en);
  assign rdata   = '1;

  genvar gp;
  generate
    for (gp = 0; gp < NCOL; gp++) begin : g_plane
      assign fg_mask[gp*DW +: DW] = {DW{fg_color[gp]}};
      assign bg_mask[gp*DW +: DW] = {DW{bg_color[gp]}};
    end
    for (gp = 0; gp < NREG; gp++) begin : g_flat
      assign shadow[gp*DW +: DW] = raw[gp];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) raw[i] <= '0;
      plane_we     <= '0;
      col_src      <= '0;
      lead_plane   <= '0;
      cmp_lead     <= 1'b0;
      wr_src       <= '0;
      shin_cpu     <= 1'b0;
      load_mode    <= '0;
      rop          <= ROP_RST;
      fg_color     <= '0;
      bg_color     <= '0;
      pix_mask     <= '0;
      shift_desc   <= 1'b0;
      dst_bit      <= '0;
      src_bit      <= '0;
      shift_len    <= LEN_RST;
      shift_reinit <= 1'b0;
      bad_access   <= 1'b0;
    end else begin
      shift_reinit <= wword & (idx == IW'(6) || idx == IW'(7));
      bad_access   <= any_acc & narrow & ~(wr_en & (addr == 4'h6));
      if (wword) begin
        raw[idx] <= wdata;
        case (idx)
          IW'(0): plane_we <= wdata[7:0];
          IW'(1): begin
            col_src    <= wdata[14:13];
            lead_plane <= wdata[11:8];
          end
          IW'(2): begin
            cmp_lead  <= ~wdata[13];
            wr_src    <= wdata[12:11];
            shin_cpu  <= wdata[10];
            load_mode <= wdata[9:8];
            rop       <= wdata[7:0];
          end
          IW'(3): fg_color <= wdata[7:0];
          IW'(4): if (col_src == 2'b00) pix_mask <= wdata;
          IW'(5): bg_color <= wdata[7:0];
          IW'(6): begin
            shift_desc <= wdata[12];
            dst_bit    <= wdata[7:4];
            src_bit    <= wdata[3:0];
          end
          default: shift_len <= wdata[LENW-1:0];
        endcase
      end
      if (wbyte) begin
        if (addr[0]) raw[idx][DW-1:8] <= wdata[7:0];
        else         raw[idx][7:0]    <= wdata[7:0];
        if (fg_byte) fg_color <= wdata[7:0];
      end
    end
  end

  AST_WINDOW_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_en |=> ($stable(shadow) && !shift_reinit && !bad_access)); // R1
  AST_MASK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wword && addr[3:1] == 3'd4 && col_src != 2'b00) |=> $stable(pix_mask)); // R7
  AST_REINIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_reinit |-> $past(eng_en && wr_en && wsize && !addr[0] && addr[3:2] == 2'b11)); // R8
  AST_BYTE_NO_ROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wbyte && addr[3:1] == 3'd2) |=> ($stable(rop) && $stable(wr_src) && bad_access)); // R11
  AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> $past(eng_en && (wr_en || rd_en))); // R11
endmodule

// File: tb/test_plane_ctl_regs.sv
`timescale 1ns/1ps
module test_plane_ctl_regs;
  logic clk = 1'b0, rst_n = 1'b0, eng_en = 1'b1, wr_en = 1'b0, rd_en = 1'b0, wsize = 1'b1;
  logic [3:0]   addr = '0;
  logic [15:0]  wdata = '0, rdata;
  logic [7:0]   plane_we, rop, fg_color, bg_color;
  logic [1:0]   col_src, wr_src, load_mode;
  logic [3:0]   lead_plane, dst_bit, src_bit;
  logic         cmp_lead, shin_cpu, shift_desc, shift_reinit, bad_access;
  logic [63:0]  fg_mask, bg_mask;
  logic [15:0]  pix_mask;
  logic [11:0]  shift_len;
  logic [127:0] shadow;

  int total = 0, bad = 0;
  logic [15:0] sh [8];

  typedef struct { string req; int sel; logic [127:0] exp; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  plane_ctl_regs i_plane_ctl_regs (.*);

  function automatic logic [127:0] probe(int sel);
    case (sel)
      0: return 128'(plane_we);   1: return 128'(col_src);
      2: return 128'(lead_plane); 3: return 128'(cmp_lead);
      4: return 128'(wr_src);     5: return 128'(shin_cpu);
      6: return 128'(load_mode);  7: return 128'(rop);
      8: return 128'(fg_color);   9: return 128'(bg_color);
      10: return 128'(fg_mask);   11: return 128'(bg_mask);
      12: return 128'(pix_mask);  13: return 128'(shift_desc);
      14: return 128'(dst_bit);   15: return 128'(src_bit);
      16: return 128'(shift_len); 17: return 128'(shift_reinit);
      18: return 128'(bad_access); 19: return 128'(rdata);
      default: return shadow;
    endcase
  endfunction

  function automatic logic [127:0] sh_flat();
    logic [127:0] f;
    for (int i = 0; i < 8; i++) f[i*16 +: 16] = sh[i];
    return f;
  endfunction

  task automatic expect_v(string req, int sel, logic [127:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic access(logic en, logic w, logic r, logic [3:0] a, logic sz, logic [15:0] d);
    @(negedge clk);
    eng_en = en; wr_en = w; rd_en = r; addr = a; wsize = sz; wdata = d;
    if (en && w) begin
      if (sz && !a[0]) sh[a[3:1]] = d;
      else if (a[0]) sh[a[3:1]][15:8] = d[7:0];
      else sh[a[3:1]][7:0] = d[7:0];
    end
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0; eng_en = 1'b1;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [127:0] act;
        it = q.pop_front();
        act = probe(it.sel);
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #(5.0 * 100000);
    bad++; total++;
    $display("FAIL watchdog: all requirements actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    for (int i = 0; i < 8; i++) sh[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12 reset state
    expect_v("R12", 7, 128'hF0);  expect_v("R12", 16, 128'h00F);
    expect_v("R12", 0, 0);        expect_v("R12", 20, 0);
    expect_v("R12", 17, 0);       expect_v("R12", 18, 0);
    idle();
    access(1, 1, 0, 4'h0, 1, 16'hFF5A);
    expect_v("R3", 0, 128'h5A);   expect_v("R9", 20, sh_flat());
    access(1, 1, 0, 4'h2, 1, 16'h4B00);
    expect_v("R4", 1, 2);         expect_v("R4", 2, 4'hB);
    access(1, 1, 0, 4'h8, 1, 16'h1234);
    expect_v("R7", 12, 0);
    access(1, 1, 0, 4'h2, 1, 16'h0300);
    access(1, 1, 0, 4'h8, 1, 16'hBEEF);
    expect_v("R7", 12, 128'hBEEF);
    access(1, 1, 0, 4'h4, 1, 16'h2D3C);
    expect_v("R5", 3, 0); expect_v("R5", 4, 1); expect_v("R5", 5, 1);
    expect_v("R5", 6, 1); expect_v("R5", 7, 128'h3C);
    access(1, 1, 0, 4'h4, 1, 16'h1255);
    expect_v("R5", 3, 1); expect_v("R5", 4, 2); expect_v("R5", 5, 0);
    expect_v("R5", 6, 2); expect_v("R5", 7, 128'h55);
    access(1, 1, 0, 4'h6, 1, 16'h00A5);
    expect_v("R6", 8, 128'hA5);   expect_v("R6", 10, 128'h0000_FFFF_0000_FFFF);
    access(1, 1, 0, 4'hA, 1, 16'h001C);
    expect_v("R6", 9, 128'h1C);   expect_v("R6", 11, 128'hFFFF_FFFF_0000_0000);
    access(1, 1, 0, 4'hC, 1, 16'h10A7);
    expect_v("R8", 13, 1); expect_v("R8", 14, 4'hA); expect_v("R8", 15, 4'h7);
    expect_v("R8", 17, 1);
    idle();
    expect_v("R8", 17, 0);
    access(1, 1, 0, 4'hE, 1, 16'hF123);
    expect_v("R8", 16, 128'h123); expect_v("R8", 17, 1);
    expect_v("R9", 20, sh_flat());
    access(1, 1, 0, 4'h6, 0, 16'hAB33);
    expect_v("R11", 8, 128'h33);  expect_v("R11", 10, 128'h0000_0000_FFFF_FFFF);
    expect_v("R11", 18, 0);       expect_v("R10", 20, sh_flat());
    access(1, 1, 0, 4'h5, 0, 16'h0077);
    expect_v("R10", 20, sh_flat()); expect_v("R11", 7, 128'h55);
    expect_v("R11", 18, 1);
    access(1, 1, 0, 4'h4, 0, 16'h00FF);
    expect_v("R11", 7, 128'h55);  expect_v("R11", 18, 1);
    expect_v("R10", 20, sh_flat());
    access(1, 1, 0, 4'h7, 1, 16'h0099);
    expect_v("R10", 20, sh_flat()); expect_v("R10", 8, 128'h33);
    expect_v("R11", 18, 1);
    access(1, 1, 0, 4'hC, 0, 16'h0001);
    expect_v("R11", 17, 0);       expect_v("R11", 15, 4'h7);
    access(1, 0, 1, 4'h2, 0, 16'h0);
    expect_v("R11", 18, 1);       expect_v("R2", 19, 128'hFFFF);
    access(1, 0, 1, 4'h2, 1, 16'h0);
    expect_v("R2", 18, 0);        expect_v("R2", 19, 128'hFFFF);
    access(0, 1, 0, 4'h0, 1, 16'h0011);
    expect_v("R1", 0, 128'h5A);   expect_v("R1", 20, sh_flat());
    expect_v("R1", 18, 0);
    access(0, 1, 0, 4'hC, 1, 16'h0000);
    expect_v("R1", 17, 0);        expect_v("R1", 14, 4'hA);
    @(negedge clk);
    eng_en = 1'b0; rd_en = 1'b1; wsize = 1'b0; addr = 4'h3;
    #0.5;
    total++;
    if (rdata !== 16'hFFFF) begin
      bad++;
      $display("FAIL R1 disabled read actual=%0h expected=ffff", rdata);
    end
    @(posedge clk); #1;
    rd_en = 1'b0; eng_en = 1'b1;
    expect_v("R1", 18, 0);
    idle(); idle();
    @(negedge clk); @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule